// File: doc/BRIEF.md
# I2C Slave Receiver with Buffered Byte Hand-off

This block is a bus-side I2C slave. Serial data is shifted in from the synchronized SDA line on each rising SCL edge, and each finished byte that the block accepts is copied into a receive buffer. A host reads that buffer through a small register port. The block matches either a 7-bit or a 10-bit own address. It acknowledges the address and every data byte that follows, by pulling SDA low through an open-drain style output enable.

Flags tell the host when the buffer holds an unread byte and when an incoming byte was refused. A sticky interrupt flag, mirrored on `irq_o`, is raised on every acknowledged or refused byte. Bus START and STOP conditions are tracked in status bits, and selected modes also raise the interrupt on them. For a read addressed to the slave, the block shifts a host-written transmit byte out on SDA, most significant bit first. It keeps sending while the master acknowledges.

The register map uses a 2-bit offset:
- Offset 0, control: bit7 enable, bit6 overflow (write 0 to clear), bits5:4 upper two bits of the 10-bit address, bits3:0 mode.
- Offset 1, status: bit4 interrupt (write 0 to clear), bit3 direction of the last address (1 = read), bit2 STOP seen, bit1 START seen, bit0 buffer full.
- Offset 2, data: a read returns the receive buffer, and a read strobe clears buffer full. A write loads the transmit byte.
- Offset 3: the low eight bits of the own address. Bits 6:0 form the 7-bit address.

Top module: `i2c_rxbuf_slave`

## Requirements
- R1: With control bit7 at 0 the block never pulls SDA low, acknowledges no byte, and keeps status bits 2:1 at 0.
- R2: In mode 0 (7-bit) the block acknowledges an address byte whose bits 7:1 equal own address bits 6:0. It then loads that byte into the buffer, sets buffer full and the interrupt flag, and records bit 0 as the direction. A byte that does not match gets no acknowledge and raises no interrupt.
- R3: After an acknowledged write address, each data byte is acknowledged and placed in the receive buffer, with buffer full and the interrupt flag set.
- R4: A byte completing while buffer full or overflow is already set gets no acknowledge and leaves the buffer unchanged, but sets the interrupt flag. If buffer full was set, the overflow flag is also set.
- R5: Buffer full clears on a host read of offset 2. Overflow survives that read, and clears only when the host writes control bit6 as 0.
- R6: A START sets status bit1 and clears bit2. A STOP sets bit2 and clears bit1.
- R7: START and STOP raise the interrupt flag only in modes 2, 3 and 4. They do not in modes 0 and 1.
- R8: In modes 1 and 3 (10-bit) the first byte must be 11110, then control bits 5:4, then the R/W bit, and the second byte must equal offset 3. Each matching byte is acknowledged. A first byte with R/W=1 is acknowledged only after a full write-address match made since the last STOP.
- R9: After an acknowledged read address, the transmit byte is driven MSB first, one bit per SCL low phase. The byte is reloaded and sent again when the master acknowledges (which also sets the interrupt flag), and SDA is released for good on a master NACK.
- R10: The interrupt flag stays set until the host writes status bit4 as 0. Writing it as 1 has no effect.
- R11: In mode 4 no address is ever acknowledged, while START and STOP tracking continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for the current offset |
| irq_o | output | 1 | Interrupt flag |

## Verification
Some rules hold on every cycle, and assertions check them:
- SDA is released while disabled and while waiting for the master's acknowledge.
- A refused byte never drives an acknowledge and never changes the buffer.
- Buffer full follows every load, and overflow follows a refusal with the buffer full.
- START and STOP status bits never hold together, and the interrupt flag stays set until it is cleared.

Other behaviour needs whole bus transactions, which only the bench's scenarios provide. These cover address matching in both widths, the repeated-START read rule in 10-bit mode, the MSB-first transmit order with master ACK and NACK, and the fact that overflow survives a buffer read.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  localparam logic [1:0] OFS_CTRL = 2'd0;
  localparam logic [1:0] OFS_STAT = 2'd1;
  localparam logic [1:0] OFS_DATA = 2'd2;
  localparam logic [1:0] OFS_OWN  = 2'd3;
  localparam logic [4:0] TEN_BIT_TAG = 5'b11110;

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_TXACK, ST_WAIT} slv_state_e;
  typedef enum logic [1:0] {K_ADDR1, K_ADDR2, K_DATA} byte_kind_e;

  function automatic logic mode_is_slave(input logic [3:0] m);
    return m <= 4'd3;
  endfunction
  function automatic logic mode_is_10b(input logic [3:0] m);
    return (m == 4'd1) || (m == 4'd3);
  endfunction
  function automatic logic mode_sp_irq(input logic [3:0] m);
    return (m == 4'd2) || (m == 4'd3) || (m == 4'd4);
  endfunction
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int LAST = STAGES - 1;
  logic [LAST:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[LAST-1:0], scl_i};
          sda_pipe <= {sda_pipe[LAST-1:0], sda_i};
        end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_pipe[LAST];
      sda_d <= sda_pipe[LAST];
    end

  assign sda_s_o    = sda_pipe[LAST];
  assign scl_rise_o = scl_pipe[LAST] & ~scl_d;
  assign scl_fall_o = ~scl_pipe[LAST] & scl_d;
  // conditions only while SCL stays high
  assign start_o    = scl_pipe[LAST] & scl_d & sda_d & ~sda_pipe[LAST];
  assign stop_o     = scl_pipe[LAST] & scl_d & ~sda_d & sda_pipe[LAST];

  a_r6_start_stop_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && stop_o));
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [3:0] mode_i,
  input  logic [7:0] own_lo_i,
  input  logic [1:0] own_hi_i,
  input  logic       bf_i,
  input  logic       ovf_i,
  input  logic [7:0] tx_byte_i,
  input  logic       sda_s_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  output logic       sda_oe_o,
  output logic       load_o,
  output logic       refuse_o,
  output logic       irq_set_o,
  output logic [7:0] rx_byte_o,
  output logic       rw_o
);
  slv_state_e state_q;
  byte_kind_e kind_q;
  logic [7:0] sr_q;
  logic [3:0] cnt_q;
  logic       ack_on_q, go_tx_q, ten_ok_q, oe_q, rw_q;
  logic       byte_done, hit, accept, refuse, mack;
  logic [7:0] rx_byte;

  assign rx_byte   = {sr_q[6:0], sda_s_i};
  assign byte_done = (state_q == ST_RX) && scl_rise_i && (cnt_q == 4'd7);

  always_comb begin
    hit = 1'b0;
    unique case (kind_q)
      K_ADDR1: hit = mode_is_10b(mode_i)
                     ? (rx_byte[7:3] == TEN_BIT_TAG) && (rx_byte[2:1] == own_hi_i) &&
                       (!rx_byte[0] || ten_ok_q)
                     : (rx_byte[7:1] == own_lo_i[6:0]);
      K_ADDR2: hit = (rx_byte == own_lo_i);
      default: hit = 1'b1;
    endcase
    hit = hit && mode_is_slave(mode_i);
  end

  assign accept = byte_done && hit && !(bf_i || ovf_i);
  assign refuse = byte_done && hit && (bf_i || ovf_i);
  assign mack   = (state_q == ST_TXACK) && scl_rise_i && !sda_s_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      kind_q   <= K_ADDR1;
      sr_q     <= '0;
      cnt_q    <= '0;
      ack_on_q <= 1'b0;
      go_tx_q  <= 1'b0;
      ten_ok_q <= 1'b0;
      oe_q     <= 1'b0;
      rw_q     <= 1'b0;
    end else if (!en_i) begin
      state_q  <= ST_IDLE;
      oe_q     <= 1'b0;
      ten_ok_q <= 1'b0;
      ack_on_q <= 1'b0;
    end else if (start_i) begin
      state_q  <= mode_is_slave(mode_i) ? ST_RX : ST_IDLE;
      kind_q   <= K_ADDR1;
      cnt_q    <= '0;
      oe_q     <= 1'b0;
      ack_on_q <= 1'b0;
    end else if (stop_i) begin
      state_q  <= ST_IDLE;
      oe_q     <= 1'b0;
      ten_ok_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: if (scl_rise_i) begin
          sr_q  <= rx_byte;
          cnt_q <= cnt_q + 4'd1;
          if (byte_done) begin
            if (accept) begin
              state_q  <= ST_ACK;
              ack_on_q <= 1'b0;
              go_tx_q  <= (kind_q == K_ADDR1) && rx_byte[0];
              unique case (kind_q)
                K_ADDR1: begin
                  rw_q   <= rx_byte[0];
                  kind_q <= (mode_is_10b(mode_i) && !rx_byte[0]) ? K_ADDR2 : K_DATA;
                end
                K_ADDR2: begin
                  ten_ok_q <= 1'b1;
                  kind_q   <= K_DATA;
                end
                default: kind_q <= K_DATA;
              endcase
            end else begin
              state_q <= ST_WAIT;
            end
          end
        end
        ST_ACK: if (scl_fall_i) begin
          if (!ack_on_q) begin
            ack_on_q <= 1'b1;
            oe_q     <= 1'b1;
          end else begin
            ack_on_q <= 1'b0;
            cnt_q    <= '0;
            if (go_tx_q) begin
              sr_q    <= tx_byte_i;
              oe_q    <= ~tx_byte_i[7];
              state_q <= ST_TX;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_rise_i) cnt_q <= cnt_q + 4'd1;
          if (scl_fall_i) begin
            if (cnt_q == 4'd8) begin
              oe_q    <= 1'b0;
              state_q <= ST_TXACK;
            end else begin
              sr_q <= {sr_q[6:0], 1'b0};
              oe_q <= ~sr_q[6];
            end
          end
        end
        ST_TXACK: if (scl_rise_i) begin
          if (!sda_s_i) begin
            state_q  <= ST_ACK;
            ack_on_q <= 1'b1;
            go_tx_q  <= 1'b1;
          end else begin
            state_q <= ST_WAIT;
          end
        end
        default: ;
      endcase
    end

  assign sda_oe_o  = oe_q;
  assign load_o    = accept;
  assign refuse_o  = refuse;
  assign irq_set_o = accept | refuse | mack;
  assign rx_byte_o = rx_byte;
  assign rw_o      = rw_q;

  a_r1_released_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !sda_oe_o);
  a_r4_refuse_no_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refuse_o && en_i && !start_i && !stop_i |=> !sda_oe_o && state_q == ST_WAIT);
  a_r9_release_for_master_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_TXACK |-> !sda_oe_o);
endmodule

// File: rtl/i2c_host_regs.sv
module i2c_host_regs
  import i2c_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic       re_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       load_i,
  input  logic       refuse_i,
  input  logic       irq_set_i,
  input  logic [7:0] rx_byte_i,
  input  logic       rw_i,
  input  logic       start_i,
  input  logic       stop_i,
  output logic       en_o,
  output logic [3:0] mode_o,
  output logic [7:0] own_lo_o,
  output logic [1:0] own_hi_o,
  output logic       bf_o,
  output logic       ovf_o,
  output logic [7:0] tx_byte_o,
  output logic       irq_o
);
  logic       en_q, ovf_q, bf_q, irq_q, s_q, p_q;
  logic [3:0] mode_q;
  logic [1:0] own_hi_q;
  logic [7:0] own_lo_q, rx_q, tx_q;
  logic       sp_evt, irq_clr;

  assign sp_evt  = en_q && mode_sp_irq(mode_q) && (start_i || stop_i);
  assign irq_clr = we_i && (addr_i == OFS_STAT) && !wdata_i[4];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      en_q <= 1'b0; ovf_q <= 1'b0; bf_q <= 1'b0; irq_q <= 1'b0;
      s_q <= 1'b0; p_q <= 1'b0; mode_q <= '0; own_hi_q <= '0;
      own_lo_q <= '0; rx_q <= '0; tx_q <= '0;
    end else begin
      if (we_i) begin
        unique case (addr_i)
          OFS_CTRL: begin
            en_q     <= wdata_i[7];
            own_hi_q <= wdata_i[5:4];
            mode_q   <= wdata_i[3:0];
            if (!wdata_i[6]) ovf_q <= 1'b0;
          end
          OFS_STAT: if (!wdata_i[4]) irq_q <= 1'b0;
          OFS_DATA: tx_q <= wdata_i;
          default:  own_lo_q <= wdata_i;
        endcase
      end
      if (re_i && addr_i == OFS_DATA) bf_q <= 1'b0;
      // hardware events win over same-cycle host clears
      if (load_i) begin
        rx_q <= rx_byte_i;
        bf_q <= 1'b1;
      end
      if (refuse_i && bf_q) ovf_q <= 1'b1;
      if (irq_set_i || sp_evt) irq_q <= 1'b1;
      if (!en_q) begin
        s_q <= 1'b0;
        p_q <= 1'b0;
      end else if (start_i) begin
        s_q <= 1'b1;
        p_q <= 1'b0;
      end else if (stop_i) begin
        s_q <= 1'b0;
        p_q <= 1'b1;
      end
    end

  always_comb
    unique case (addr_i)
      OFS_CTRL: rdata_o = {en_q, ovf_q, own_hi_q, mode_q};
      OFS_STAT: rdata_o = {3'b000, irq_q, rw_i, p_q, s_q, bf_q};
      OFS_DATA: rdata_o = rx_q;
      default:  rdata_o = own_lo_q;
    endcase

  assign en_o      = en_q;
  assign mode_o    = mode_q;
  assign own_lo_o  = own_lo_q;
  assign own_hi_o  = own_hi_q;
  assign bf_o      = bf_q;
  assign ovf_o     = ovf_q;
  assign tx_byte_o = tx_q;
  assign irq_o     = irq_q;

  a_r4_load_refuse_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && refuse_i));
  a_r2_bf_after_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> bf_q);
  a_r4_ovf_on_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refuse_i && bf_q |=> ovf_q);
  a_r4_buf_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refuse_i |=> $stable(rx_q));
  a_r6_sp_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(s_q && p_q));
  a_r10_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q && !irq_clr |=> irq_q);
endmodule

// File: rtl/i2c_rxbuf_slave.sv
module i2c_rxbuf_slave #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic       reg_we_i,
  input  logic       reg_re_i,
  input  logic [1:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       irq_o
);
  logic       sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic       en, bf, ovf, load, refuse, irq_set, rw;
  logic [3:0] mode;
  logic [7:0] own_lo, tx_byte, rx_byte;
  logic [1:0] own_hi;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_s_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  i2c_slave_fsm u_fsm (
    .clk_i, .rst_ni, .en_i(en), .mode_i(mode), .own_lo_i(own_lo), .own_hi_i(own_hi),
    .bf_i(bf), .ovf_i(ovf), .tx_byte_i(tx_byte), .sda_s_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .start_i(start_ev), .stop_i(stop_ev),
    .sda_oe_o, .load_o(load), .refuse_o(refuse), .irq_set_o(irq_set),
    .rx_byte_o(rx_byte), .rw_o(rw)
  );

  i2c_host_regs u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .re_i(reg_re_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .load_i(load), .refuse_i(refuse),
    .irq_set_i(irq_set), .rx_byte_i(rx_byte), .rw_i(rw), .start_i(start_ev),
    .stop_i(stop_ev), .en_o(en), .mode_o(mode), .own_lo_o(own_lo), .own_hi_o(own_hi),
    .bf_o(bf), .ovf_o(ovf), .tx_byte_o(tx_byte), .irq_o
  );
endmodule

// File: tb/i2c_rxbuf_slave_tb_top.sv
module i2c_rxbuf_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_bus, sda_oe, irq;
  logic we = 1'b0, re = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  i2c_rxbuf_slave dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = Q);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  // read; strobe clears buffer full when a==2
  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; re = 1'b1; #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic bus_start;
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(); m_scl = 1'b1; wq(); m_scl = 1'b0;
    end
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(Q/2);
    ack = !sda_bus; wq(Q/2); m_scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); m_scl = 1'b1; wq(Q/2); b[i] = sda_bus; wq(Q/2); m_scl = 1'b0;
    end
    m_sda = !mack; wq(); m_scl = 1'b1; wq(); m_scl = 1'b0; wq(); m_sda = 1'b1;
  endtask

  task automatic clr_irq;
    wr(2'd1, 8'h00);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(2'd0, d); chk("reset ctrl", d, 8'h00);
    rd(2'd1, d); chk("reset status", d, 8'h00);
    chk("reset irq", irq, 0);
    chk("reset sda_oe", sda_oe, 0);
  endtask

  task automatic t_disabled;
    logic ack; logic [7:0] d;
    wr(2'd3, 8'h5A); wr(2'd0, 8'h00);
    bus_start;
    rd(2'd1, d); chk("R1 no start bit when off", d[1], 0);
    send_byte(8'hB4, ack); chk("R1 no ack when off", ack, 0);
    chk("R1 no irq when off", irq, 0);
    bus_stop;
    rd(2'd1, d); chk("R1 no stop bit when off", d[2], 0);
  endtask

  task automatic t_write7;
    logic ack; logic [7:0] d;
    wr(2'd0, 8'h80);
    bus_start;
    rd(2'd1, d); chk("R6 start bit", d, 8'h02);
    chk("R7 no sp irq mode0", irq, 0);
    send_byte(8'hB4, ack); chk("R2 addr ack", ack, 1);
    rd(2'd1, d); chk("R2 status after addr", d, 8'h13);
    rd(2'd2, d); chk("R2 addr in buffer", d, 8'hB4);
    rd(2'd1, d); chk("R5 bf cleared by read", d[0], 0);
    wr(2'd1, 8'h10); chk("R10 write 1 keeps irq", irq, 1);
    clr_irq; chk("R10 write 0 clears irq", irq, 0);
    send_byte(8'h3C, ack); chk("R3 data ack", ack, 1);
    chk("R3 irq on data", irq, 1);
    rd(2'd2, d); chk("R3 data in buffer", d, 8'h3C);
    clr_irq;
    bus_stop;
    rd(2'd1, d); chk("R6 stop bit", d & 8'h06, 8'h04);
  endtask

  task automatic t_mismatch;
    logic ack;
    bus_start;
    send_byte(8'hB6, ack); chk("R2 mismatch nack", ack, 0);
    chk("R2 mismatch no irq", irq, 0);
    bus_stop;
  endtask

  task automatic t_refuse;
    logic ack; logic [7:0] d;
    bus_start;
    send_byte(8'hB4, ack); chk("R2 addr ack", ack, 1);
    clr_irq;
    send_byte(8'h11, ack); chk("R4 refused nack", ack, 0);
    chk("R4 irq on refuse", irq, 1);
    rd(2'd0, d); chk("R4 ovf set", d, 8'hC0);
    rd(2'd2, d); chk("R4 buffer kept", d, 8'hB4);
    bus_stop; clr_irq;
    rd(2'd0, d); chk("R5 ovf survives read", d[6], 1);
    bus_start;
    send_byte(8'hB4, ack); chk("R4 refused on ovf", ack, 0);
    bus_stop; clr_irq;
    wr(2'd0, 8'hC0);
    rd(2'd0, d); chk("R5 write 1 keeps ovf", d[6], 1);
    wr(2'd0, 8'h80);
    rd(2'd0, d); chk("R5 ovf cleared by write 0", d, 8'h80);
    bus_start;
    send_byte(8'hB4, ack); chk("R5 accepted after clear", ack, 1);
    rd(2'd2, d); clr_irq;
    bus_stop;
  endtask

  task automatic t_sp_irq;
    logic ack;
    wr(2'd0, 8'h82); clr_irq;
    bus_start; chk("R7 start irq mode2", irq, 1);
    clr_irq;
    bus_stop; chk("R7 stop irq mode2", irq, 1);
    wr(2'd0, 8'h84); clr_irq;
    bus_start; chk("R7 start irq mode4", irq, 1);
    clr_irq;
    send_byte(8'hB4, ack); chk("R11 no ack mode4", ack, 0);
    chk("R11 no byte irq mode4", irq, 0);
    bus_stop; clr_irq;
  endtask

  task automatic t_10bit;
    logic ack; logic [7:0] d;
    wr(2'd3, 8'hC3); wr(2'd0, 8'hA1); wr(2'd2, 8'hA5);
    bus_start;
    send_byte(8'hF4, ack); chk("R8 first byte ack", ack, 1);
    rd(2'd2, d); chk("R8 first byte buffer", d, 8'hF4);
    send_byte(8'hC3, ack); chk("R8 second byte ack", ack, 1);
    rd(2'd2, d);
    send_byte(8'h77, ack); chk("R3 10b data ack", ack, 1);
    rd(2'd2, d); chk("R3 10b data", d, 8'h77);
    bus_start;
    send_byte(8'hF5, ack); chk("R8 read after match ack", ack, 1);
    recv_byte(1'b0, d); chk("R9 10b tx byte", d, 8'hA5);
    chk("R9 released after nack", sda_bus, 1);
    rd(2'd2, d); clr_irq;
    bus_stop;
    bus_start;
    send_byte(8'hF5, ack); chk("R8 read without match nack", ack, 0);
    bus_stop;
    bus_start;
    send_byte(8'hF2, ack); chk("R8 wrong upper bits nack", ack, 0);
    bus_stop; clr_irq;
  endtask

  task automatic t_read7;
    logic ack; logic [7:0] d;
    wr(2'd0, 8'h80); wr(2'd3, 8'h5A); wr(2'd2, 8'h96);
    bus_start;
    send_byte(8'hB5, ack); chk("R2 read addr ack", ack, 1);
    rd(2'd1, d); chk("R2 rw bit read", d[3], 1);
    rd(2'd2, d); clr_irq;
    recv_byte(1'b1, d); chk("R9 first tx byte", d, 8'h96);
    chk("R9 irq on master ack", irq, 1);
    recv_byte(1'b0, d); chk("R9 second tx byte", d, 8'h96);
    wq(); chk("R9 sda released", sda_oe, 0);
    bus_stop; clr_irq;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    wq(4);
    t_reset;
    t_disabled;
    t_write7;
    t_mismatch;
    t_refuse;
    t_sp_irq;
    t_10bit;
    t_read7;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule